// File: doc/BRIEF.md
# Clock Root Configuration Update Controller

This block governs a single clock root. Software writes a source select, a pre-divider value, a mode field, a hardware gating enable and three counter values (M, N, D) into a staged register set. None of these writes reaches the active configuration on its own. When software sets the update bit in the command register, the controller waits until the root is running. It then gates the outgoing clock low and waits for the newly selected source to report valid. After that it loads the whole staged set into the active outputs in one cycle, ungates the new source and clears the update bit. Software polls that bit to learn that the change has landed.

The root runs while software forces it on, or while a downstream consumer requests it. When hardware gating is turned off in the active configuration, the root runs at all times. A status bit in the command register reports whether the root is off. Per-register pending flags in the command register show which staged registers have been written since the last completed update. The divider arithmetic lives downstream and is fed from the active configuration outputs.

The register port is a plain synchronous write port with a combinational read. It has no handshake: a write is accepted in every cycle in which `reg_we` is high. Reads always return the staged copy, never the active one.

Top module: `crc_root_ctrl`

## Requirements
- R1: After reset, the command word reads 0x8000_0000, with the root-off bit 31 set and every other bit clear. The config word reads 0x0010_0000, with only the gating enable bit 20 set. All active outputs are zero and no gate is open.
- R2: Writes to the config word (address 1), M (address 2), N (address 3) and D (address 4) read back from the staged copy. They leave the active outputs unchanged until an update completes. Config fields: pre-divider at bits DIV_W-1:0, source select at 10:8, mode at 13:12, gating enable at 20.
- R3: A write to the config, N, M or D word sets command bit 4, 5, 6 or 7 respectively. These bits clear in the same cycle as the update bit.
- R4: Writing 1 to command bit 0 (address 0) with the root running and the new source valid copies the staged set to the active outputs. Bit 0 and the pending flags then read 0 within 4 cycles.
- R5: An update issued while the root is off stays pending with the active outputs unchanged. It completes once the root turns on.
- R6: Command bit 1 keeps the root on with no downstream request. Command bit 31 reads 0 while the root runs and 1 while it is off. The `root_on` output mirrors the running state.
- R7: With gating enabled in the active config, the root runs only while it is forced or requested. With gating disabled, it runs regardless of both.
- R8: During an update every gate is closed before the active source changes. While the new source is not valid, the gates stay closed and the update bit stays set.
- R9: At most one gate is open, only the gate of the active source, and only while the root runs.
- R10: Writing 0 to command bit 0 does not cancel a pending update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_valid | input | NSRC | Per-source clock valid |
| src_clk | input | NSRC | Source clocks |
| dn_req | input | 1 | Downstream enable request |
| root_on | output | 1 | Root is running |
| act_src | output | 3 | Active source select |
| act_div | output | DIV_W | Active pre-divider |
| act_mode | output | 2 | Active mode |
| act_hwgate | output | 1 | Active hardware gating enable |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |
| src_gate | output | NSRC | Per-source gate enables |
| clk_out | output | 1 | Selected, gated clock |

## Verification
The hardest state to reach from the ports is a switch stalled halfway. In that state the old source is already gated off, the new one is not yet valid, and software keeps writing to the command word. The bench holds one `src_valid` bit low and stages that source as the target. It issues the update and then writes 0 to the update bit. It checks that the gates stay closed and the active outputs hold. Only then does it raise the valid bit. A second hard case is an update issued with the root off. Reaching it requires hardware gating to be active and both the downstream request and the force bit to be low before the update bit is written.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam logic [2:0] A_CMD = 3'd0;
  localparam logic [2:0] A_CFG = 3'd1;
  localparam logic [2:0] A_M   = 3'd2;
  localparam logic [2:0] A_N   = 3'd3;
  localparam logic [2:0] A_D   = 3'd4;

  localparam int B_UPD   = 0;
  localparam int B_FORCE = 1;
  localparam int B_DIRTY = 4;
  localparam int B_OFF   = 31;

  localparam int F_SRC_LO  = 8;
  localparam int F_MODE_LO = 12;
  localparam int F_HWG     = 20;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_GATE_OFF, SQ_GATE_ON} seq_state_t;
endpackage

// File: rtl/crc_stage.sv
module crc_stage import crc_pkg::*; #(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             done,
  input  logic             root_on,
  output logic [DIV_W-1:0] stg_div,
  output logic [SEL_W-1:0] stg_src,
  output logic [1:0]       stg_mode,
  output logic             stg_hwg,
  output logic [MND_W-1:0] stg_m,
  output logic [MND_W-1:0] stg_n,
  output logic [MND_W-1:0] stg_d,
  output logic             upd,
  output logic             force_en,
  output logic [3:0]       dirty,
  output logic [31:0]      rdata
);
  logic wr_cmd, wr_cfg, wr_m, wr_n, wr_d;
  assign wr_cmd = we && (addr == A_CMD);
  assign wr_cfg = we && (addr == A_CFG);
  assign wr_m   = we && (addr == A_M);
  assign wr_n   = we && (addr == A_N);
  assign wr_d   = we && (addr == A_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_div  <= '0;
      stg_src  <= '0;
      stg_mode <= '0;
      stg_hwg  <= 1'b1;
      stg_m    <= '0;
      stg_n    <= '0;
      stg_d    <= '0;
      force_en <= 1'b0;
    end else begin
      if (wr_cfg) begin
        stg_div  <= wdata[DIV_W-1:0];
        stg_src  <= wdata[F_SRC_LO +: SEL_W];
        stg_mode <= wdata[F_MODE_LO +: 2];
        stg_hwg  <= wdata[F_HWG];
      end
      if (wr_m) stg_m <= wdata[MND_W-1:0];
      if (wr_n) stg_n <= wdata[MND_W-1:0];
      if (wr_d) stg_d <= wdata[MND_W-1:0];
      if (wr_cmd) force_en <= wdata[B_FORCE];
    end
  end

  // Update bit and pending flags: a write in the clearing cycle wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd   <= 1'b0;
      dirty <= '0;
    end else begin
      if (done) begin
        upd   <= 1'b0;
        dirty <= '0;
      end
      if (wr_cmd && wdata[B_UPD]) upd <= 1'b1;
      if (wr_cfg) dirty[0] <= 1'b1;
      if (wr_n)   dirty[1] <= 1'b1;
      if (wr_m)   dirty[2] <= 1'b1;
      if (wr_d)   dirty[3] <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CMD: begin
        rdata[B_UPD]          = upd;
        rdata[B_FORCE]        = force_en;
        rdata[B_DIRTY +: 4]   = dirty;
        rdata[B_OFF]          = ~root_on;
      end
      A_CFG: begin
        rdata[DIV_W-1:0]          = stg_div;
        rdata[F_SRC_LO +: SEL_W]  = stg_src;
        rdata[F_MODE_LO +: 2]     = stg_mode;
        rdata[F_HWG]              = stg_hwg;
      end
      A_M: rdata[MND_W-1:0] = stg_m;
      A_N: rdata[MND_W-1:0] = stg_n;
      A_D: rdata[MND_W-1:0] = stg_d;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_seq.sv
module crc_seq import crc_pkg::*; #(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             root_on,
  input  logic [SEL_W-1:0] stg_src,
  input  logic [NSRC-1:0]  src_valid,
  output logic             commit,
  output logic             done,
  output logic             gate_en
);
  localparam int NSEL = 1 << SEL_W;

  seq_state_t state;
  logic [NSEL-1:0] vld_pad;

  always_comb begin
    vld_pad = '0;
    for (int i = 0; i < NSRC; i++) vld_pad[i] = src_valid[i];
  end

  assign commit = root_on && (state == SQ_GATE_OFF) && vld_pad[stg_src];
  assign done   = root_on && (state == SQ_GATE_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      gate_en <= 1'b1;
    end else if (root_on) begin
      unique case (state)
        SQ_IDLE: if (upd) begin
          state   <= SQ_GATE_OFF;
          gate_en <= 1'b0;
        end
        SQ_GATE_OFF: if (commit) state <= SQ_GATE_ON;
        SQ_GATE_ON: begin
          state   <= SQ_IDLE;
          gate_en <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_root.sv
module crc_root import crc_pkg::*; #(
  parameter int NSRC  = 8,
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [DIV_W-1:0] stg_div,
  input  logic [SEL_W-1:0] stg_src,
  input  logic [1:0]       stg_mode,
  input  logic             stg_hwg,
  input  logic [MND_W-1:0] stg_m,
  input  logic [MND_W-1:0] stg_n,
  input  logic [MND_W-1:0] stg_d,
  input  logic             force_en,
  input  logic             dn_req,
  input  logic             gate_en,
  input  logic [NSRC-1:0]  src_clk,
  output logic             root_on,
  output logic [DIV_W-1:0] act_div,
  output logic [SEL_W-1:0] act_src,
  output logic [1:0]       act_mode,
  output logic             act_hwgate,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d,
  output logic [NSRC-1:0]  src_gate,
  output logic             clk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div    <= '0;
      act_src    <= '0;
      act_mode   <= '0;
      act_hwgate <= 1'b0;
      act_m      <= '0;
      act_n      <= '0;
      act_d      <= '0;
      root_on    <= 1'b0;
    end else begin
      if (commit) begin
        act_div    <= stg_div;
        act_src    <= stg_src;
        act_mode   <= stg_mode;
        act_hwgate <= stg_hwg;
        act_m      <= stg_m;
        act_n      <= stg_n;
        act_d      <= stg_d;
      end
      root_on <= force_en | dn_req | (~act_hwgate & ~rst_gate_q);
    end
  end

  // Gating is treated as enabled until the first commit so the root is off after reset.
  logic rst_gate_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_gate_q <= 1'b1;
    else if (commit) rst_gate_q <= 1'b0;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign src_gate[g] = root_on & gate_en & (act_src == SEL_W'(g));
  end

  assign clk_out = |(src_clk & src_gate);
endmodule

// File: rtl/crc_root_ctrl.sv
module crc_root_ctrl import crc_pkg::*; #(
  parameter int NSRC  = 8,
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NSRC-1:0]  src_valid,
  input  logic [NSRC-1:0]  src_clk,
  input  logic             dn_req,
  output logic             root_on,
  output logic [2:0]       act_src,
  output logic [DIV_W-1:0] act_div,
  output logic [1:0]       act_mode,
  output logic             act_hwgate,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d,
  output logic [NSRC-1:0]  src_gate,
  output logic             clk_out
);
  logic [DIV_W-1:0] stg_div;
  logic [SEL_W-1:0] stg_src;
  logic [1:0]       stg_mode;
  logic             stg_hwg;
  logic [MND_W-1:0] stg_m, stg_n, stg_d;
  logic             upd, force_en, commit, done, gate_en;
  logic [3:0]       dirty;

  crc_stage #(.DIV_W(DIV_W), .MND_W(MND_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .done(done), .root_on(root_on),
    .stg_div(stg_div), .stg_src(stg_src), .stg_mode(stg_mode), .stg_hwg(stg_hwg),
    .stg_m(stg_m), .stg_n(stg_n), .stg_d(stg_d),
    .upd(upd), .force_en(force_en), .dirty(dirty), .rdata(reg_rdata)
  );

  crc_seq #(.NSRC(NSRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .upd(upd), .root_on(root_on), .stg_src(stg_src),
    .src_valid(src_valid), .commit(commit), .done(done), .gate_en(gate_en)
  );

  crc_root #(.NSRC(NSRC), .DIV_W(DIV_W), .MND_W(MND_W)) u_root (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .stg_div(stg_div), .stg_src(stg_src), .stg_mode(stg_mode), .stg_hwg(stg_hwg),
    .stg_m(stg_m), .stg_n(stg_n), .stg_d(stg_d),
    .force_en(force_en), .dn_req(dn_req), .gate_en(gate_en), .src_clk(src_clk),
    .root_on(root_on), .act_div(act_div), .act_src(act_src), .act_mode(act_mode),
    .act_hwgate(act_hwgate), .act_m(act_m), .act_n(act_n), .act_d(act_d),
    .src_gate(src_gate), .clk_out(clk_out)
  );
endmodule

// File: rtl/crc_root_ctrl_chk.sv
module crc_root_ctrl_chk #(
  parameter int NSRC  = 8,
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic             root_on,
  input logic [2:0]       act_src,
  input logic [DIV_W-1:0] act_div,
  input logic [NSRC-1:0]  src_gate,
  input logic             upd_pend,
  input logic [3:0]       dirty
);
  // R9: never two gates open at once
  a_r9_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_gate));

  // R2 / R4: active config moves only while an update is pending
  a_r4_active_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pend |=> ($stable(act_src) && $stable(act_div)));

  // R5: pending update survives while the root is off
  a_r5_pending_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pend && !root_on) |=> upd_pend);

  // R8: the active source changes only with every gate closed
  a_r8_gates_closed_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_src) |-> (src_gate == '0));

  // R8: when the update clears the new gate is open unless the root has stopped
  a_r8_gate_open_at_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_pend) |-> ((src_gate != '0) || !root_on));

  // R3: an M write raises its pending flag
  a_r3_m_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2) |=> dirty[2]);
endmodule

bind crc_root_ctrl crc_root_ctrl_chk #(.NSRC(NSRC), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .root_on(root_on), .act_src(act_src), .act_div(act_div), .src_gate(src_gate),
  .upd_pend(upd), .dirty(dirty)
);

// File: tb/crc_root_ctrl_tb.sv
module crc_root_ctrl_tb;
  localparam int NSRC = 8, DIV_W = 5, MND_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NSRC-1:0] src_valid = '1, src_clk = '0, src_gate;
  logic dn_req = 1'b0, root_on, act_hwgate, clk_out;
  logic [2:0] act_src;
  logic [DIV_W-1:0] act_div;
  logic [1:0] act_mode;
  logic [MND_W-1:0] act_m, act_n, act_d;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  always #3 src_clk = ~src_clk;

  crc_root_ctrl #(.NSRC(NSRC), .DIV_W(DIV_W), .MND_W(MND_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_clk(src_clk), .dn_req(dn_req), .root_on(root_on), .act_src(act_src),
    .act_div(act_div), .act_mode(act_mode), .act_hwgate(act_hwgate),
    .act_m(act_m), .act_n(act_n), .act_d(act_d), .src_gate(src_gate),
    .clk_out(clk_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); chk("R1 cmd", v, 32'h8000_0000);
    rd(3'd1, v); chk("R1 cfg", v, 32'h0010_0000);
    chk("R1 gate", 32'(src_gate), 0);
    chk("R1 act", {act_src, act_div, act_m, act_n, act_d}, 0);
    chk("R6 root off", 32'(root_on), 0);
  endtask

  task automatic t_stage;
    logic [31:0] v;
    wr(3'd1, 32'h0010_2305);
    wr(3'd2, 32'h11); wr(3'd3, 32'h22); wr(3'd4, 32'h33);
    rd(3'd1, v); chk("R2 cfg readback", v, 32'h0010_2305);
    rd(3'd2, v); chk("R2 m readback", v, 32'h11);
    rd(3'd4, v); chk("R2 d readback", v, 32'h33);
    rd(3'd0, v); chk("R3 all flags", v, 32'h8000_00F0);
    chk("R2 active held", 32'(act_src), 0);
  endtask

  task automatic t_pending_off;
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wait_cyc(10);
    rd(3'd0, v); chk("R5 still pending", v, 32'h8000_00F1);
    chk("R5 active held", 32'(act_src), 0);
    dn_req = 1'b1;
    wait_cyc(6);
    rd(3'd0, v); chk("R4 update cleared", v, 32'h0);
    chk("R4 active cfg", {act_src, act_div, act_mode}, {3'd3, 5'd5, 2'd2});
    chk("R4 active mnd", {act_m, act_n, act_d}, 24'h112233);
    chk("R9 gate src3", 32'(src_gate), 32'h08);
  endtask

  task automatic t_switch_wait;
    logic [31:0] v;
    src_valid[6] = 1'b0;
    wr(3'd1, 32'h0010_0600);
    wr(3'd0, 32'h1);
    wait_cyc(3);
    chk("R8 gates closed", 32'(src_gate), 0);
    chk("R8 active held", 32'(act_src), 3);
    wr(3'd0, 32'h0);
    wait_cyc(2);
    rd(3'd0, v); chk("R10 update kept", v, 32'h11);
    chk("R8 still closed", 32'(src_gate), 0);
    src_valid[6] = 1'b1;
    wait_cyc(4);
    chk("R8 new source", 32'(act_src), 6);
    chk("R9 gate src6", 32'(src_gate), 32'h40);
    rd(3'd0, v); chk("R3 flags cleared", v, 32'h0);
  endtask

  task automatic t_force;
    logic [31:0] v;
    dn_req = 1'b0;
    wait_cyc(3);
    chk("R7 gated off", 32'(root_on), 0);
    chk("R9 no gate off", 32'(src_gate), 0);
    wr(3'd0, 32'h2);
    wait_cyc(2);
    chk("R6 forced on", 32'(root_on), 1);
    rd(3'd0, v); chk("R6 off bit low", v, 32'h2);
    chk("R9 gate forced", 32'(src_gate), 32'h40);
    wr(3'd0, 32'h0);
    wait_cyc(2);
    chk("R6 release", 32'(root_on), 0);
  endtask

  task automatic t_hwgate;
    logic [31:0] v;
    wr(3'd1, 32'h0000_0600);
    wr(3'd0, 32'h3);
    wait_cyc(6);
    wr(3'd0, 32'h0);
    wait_cyc(3);
    chk("R7 gating off runs", 32'(root_on), 1);
    rd(3'd0, v); chk("R7 cmd", v, 32'h0);
    wr(3'd1, 32'h0010_0600);
    wr(3'd0, 32'h1);
    wait_cyc(6);
    chk("R7 gating on stops", 32'(root_on), 0);
    rd(3'd0, v); chk("R7 cmd off", v, 32'h8000_0000);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_stage();
    t_pending_off();
    t_switch_wait();
    t_force();
    t_hwgate();
    summary();
    $finish;
  end
endmodule